// File: doc/BRIEF.md
# Compressed Speech Frame Parser

This block walks a bit-serial stream of compressed speech frames stored in a byte-wide memory. The stream starts at any bit address, not only at a byte boundary. A one-cycle start pulse loads that address. The parser then fetches bytes through a read port with one cycle of latency and takes bits from each byte starting at the most significant one.

Each frame is split into its fields and classified. The energy and pitch values are reported together with a frame-kind code and a one-cycle strobe. The coefficient bits that follow some frames are stepped over without being decoded. Frames have different lengths depending on their contents, so the parser must count every bit exactly. A single miscounted bit shifts every later frame.

Parsing ends when a stop frame is found. The done flag then stays high until the next start pulse.

Top module: `speech_frame_parser`

## Requirements
- R1: Bit address n selects byte n>>3 of the memory, and within that byte bit position 7-(n mod 8), so each byte is consumed starting at bit 7.
- R2: Every frame opens with a 4-bit energy field. Every multi-bit field is assembled with the first bit read as its most significant bit.
- R3: Energy 0 is a silence frame of 4 bits in total. It is reported as kind 0 with energy 0 and pitch 0.
- R4: Energy 15 is a stop frame. It is reported as kind 4 with energy 15 and pitch 0. `done` rises in the same cycle as that frame's strobe and stays high, and no further strobe appears until the next start pulse.
- R5: For any other energy, a 1-bit repeat flag follows the energy field, then a 6-bit pitch field. When the flag is 1, the frame ends there (11 bits) and is reported as kind 1 with its energy and pitch.
- R6: A frame whose repeat flag is 0 and whose pitch is 0 is unvoiced. It is reported as kind 2 after a further 18 bits are skipped (29 bits in total).
- R7: A frame whose repeat flag is 0 and whose pitch is nonzero is voiced. It is reported as kind 3 after a further 37 bits are skipped (48 bits in total).
- R8: `frame_valid` is high for exactly one cycle per frame. `frame_kind`, `frame_energy` and `frame_pitch` are meaningful in that cycle.
- R9: A start pulse loads `start_bit`, clears `done`, and begins a new stream. This holds at any bit alignment, and it holds even while an earlier stream is still being parsed, which is then abandoned.
- R10: The memory returns the byte addressed while `mem_rd` is high on the following cycle. Fields that straddle a byte boundary are parsed correctly.
- R11: After reset, `frame_valid`, `done` and `mem_rd` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that starts parsing at `start_bit` |
| start_bit | input | ADDR_W | Bit address of the first frame |
| mem_rd | output | 1 | Byte read request |
| mem_addr | output | ADDR_W-3 | Byte address of the read |
| mem_rdata | input | 8 | Byte returned one cycle after `mem_rd` |
| frame_valid | output | 1 | One-cycle strobe per parsed frame |
| frame_kind | output | 3 | 0 silence, 1 repeat, 2 unvoiced, 3 voiced, 4 stop |
| frame_energy | output | 4 | Energy field of the frame |
| frame_pitch | output | 6 | Pitch field (0 for silence and stop) |
| done | output | 1 | High from the stop frame until the next start |

## Verification
Directed streams place every frame kind side by side, including a repeat frame with pitch 0 and voiced frames at pitch 1 and 63. This separates a repeat-flag decision from a pitch-zero decision, and shows whether the skip lengths are right. The same kinds of stream are also started at unaligned bit offsets, and one stream is nothing but a stop frame beginning at bit 7. These cases make the energy and pitch fields straddle bytes and expose errors in the in-byte bit order.

Random streams of mixed frames with random coefficient bits catch any off-by-one in a skip count, because such an error desynchronises every later frame. A restart issued in the middle of a stream shows that the old stream is dropped and the new address is taken.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

  localparam int ENERGY_W      = 4;
  localparam int PITCH_W       = 6;
  localparam int UNVOICED_SKIP = 18;
  localparam int VOICED_SKIP   = 37;
  localparam int CNT_W         = $clog2(VOICED_SKIP + 1);

  typedef enum logic [2:0] {
    FK_SILENCE  = 3'd0,
    FK_REPEAT   = 3'd1,
    FK_UNVOICED = 3'd2,
    FK_VOICED   = 3'd3,
    FK_STOP     = 3'd4
  } frame_kind_t;

  typedef enum logic [2:0] {
    WS_IDLE, WS_ENERGY, WS_REPEAT, WS_PITCH, WS_SKIP, WS_DONE
  } walk_state_t;

  // Bit at in-byte offset off, counted from the most significant bit.
  function automatic logic pick_bit(input logic [7:0] b, input logic [2:0] off);
    return b[3'd7 - off];
  endfunction

  // Kind of a non-repeat frame from its pitch.
  function automatic frame_kind_t kind_of_pitch(input logic [PITCH_W-1:0] p);
    return (p == '0) ? FK_UNVOICED : FK_VOICED;
  endfunction

  // Number of coefficient bits to step over for a non-repeat frame.
  function automatic logic [CNT_W-1:0] skip_len(input logic [PITCH_W-1:0] p);
    return (p == '0) ? CNT_W'(UNVOICED_SKIP) : CNT_W'(VOICED_SKIP);
  endfunction

endpackage

// File: rtl/sfp_bit_reader.sv
module sfp_bit_reader
  import sfp_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              run,
  input  logic              take,
  output logic              mem_rd,
  output logic [ADDR_W-4:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              bit_ok,
  output logic              bit_val
);
  localparam int BYTE_AW = ADDR_W - 3;

  logic [ADDR_W-1:0]  ptr;
  logic [7:0]         cache;
  logic [BYTE_AW-1:0] cache_idx;
  logic               cache_ok;
  logic               pending;
  logic               hit;

  always_comb begin
    hit      = cache_ok && (cache_idx == ptr[ADDR_W-1:3]);
    bit_ok   = hit;
    bit_val  = pick_bit(cache, ptr[2:0]);
    mem_addr = ptr[ADDR_W-1:3];
    mem_rd   = run && !hit && !pending && !load;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr       <= '0;
      cache     <= '0;
      cache_idx <= '0;
      cache_ok  <= 1'b0;
      pending   <= 1'b0;
    end else if (load) begin
      ptr      <= load_addr;
      cache_ok <= 1'b0;
      pending  <= 1'b0;
    end else begin
      if (mem_rd) pending <= 1'b1;
      if (pending) begin
        cache     <= mem_rdata;
        cache_idx <= ptr[ADDR_W-1:3];
        cache_ok  <= 1'b1;
        pending   <= 1'b0;
      end
      if (take && hit) ptr <= ptr + 1'b1;
    end
  end

  // R10: the walker only consumes a bit the reader holds
  p_take_needs_bit_r10: assert property (@(posedge clk) disable iff (rst)
    take |-> bit_ok);
  // R10: one outstanding read at a time, answered before the next request
  p_single_read_r10: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);
  // R1: the pointer advances by exactly one bit per consumed bit
  p_ptr_step_r1: assert property (@(posedge clk) disable iff (rst)
    (take && !load) |=> (ptr == $past(ptr) + 1'b1));

endmodule

// File: rtl/sfp_frame_walker.sv
module sfp_frame_walker
  import sfp_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                bit_ok,
  input  logic                bit_val,
  output logic                run,
  output logic                take,
  output logic                frame_valid,
  output frame_kind_t         frame_kind,
  output logic [ENERGY_W-1:0] frame_energy,
  output logic [PITCH_W-1:0]  frame_pitch,
  output logic                done
);
  walk_state_t          state;
  logic [CNT_W-1:0]     cnt;
  logic [PITCH_W-1:0]   acc;
  logic [ENERGY_W-1:0]  e_reg;
  logic [PITCH_W-1:0]   p_reg;
  logic                 rep_reg;
  frame_kind_t          kind_reg;

  logic [PITCH_W-1:0]   fld;
  logic                 field_end;
  logic                 ev_silence, ev_stop, ev_repeat, ev_skip_end;

  always_comb begin
    run       = (state == WS_ENERGY) || (state == WS_REPEAT) ||
                (state == WS_PITCH)  || (state == WS_SKIP);
    take      = run && bit_ok && !start;
    fld       = {acc[PITCH_W-2:0], bit_val};
    field_end = take && (cnt == CNT_W'(1));
    ev_silence  = field_end && (state == WS_ENERGY) && (fld[ENERGY_W-1:0] == '0);
    ev_stop     = field_end && (state == WS_ENERGY) && (&fld[ENERGY_W-1:0]);
    ev_repeat   = field_end && (state == WS_PITCH) && rep_reg;
    ev_skip_end = field_end && (state == WS_SKIP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= WS_IDLE;
      cnt          <= '0;
      acc          <= '0;
      e_reg        <= '0;
      p_reg        <= '0;
      rep_reg      <= 1'b0;
      kind_reg     <= FK_SILENCE;
      frame_valid  <= 1'b0;
      frame_kind   <= FK_SILENCE;
      frame_energy <= '0;
      frame_pitch  <= '0;
      done         <= 1'b0;
    end else if (start) begin
      state       <= WS_ENERGY;
      cnt         <= CNT_W'(ENERGY_W);
      frame_valid <= 1'b0;
      done        <= 1'b0;
    end else begin
      frame_valid <= 1'b0;
      if (take) begin
        acc <= fld;
        cnt <= cnt - 1'b1;
      end
      if (field_end) begin
        unique case (state)
          WS_ENERGY: begin
            if (ev_silence) begin
              frame_valid  <= 1'b1;
              frame_kind   <= FK_SILENCE;
              frame_energy <= '0;
              frame_pitch  <= '0;
              cnt          <= CNT_W'(ENERGY_W);
            end else if (ev_stop) begin
              frame_valid  <= 1'b1;
              frame_kind   <= FK_STOP;
              frame_energy <= '1;
              frame_pitch  <= '0;
              done         <= 1'b1;
              state        <= WS_DONE;
            end else begin
              e_reg <= fld[ENERGY_W-1:0];
              cnt   <= CNT_W'(1);
              state <= WS_REPEAT;
            end
          end
          WS_REPEAT: begin
            rep_reg <= bit_val;
            cnt     <= CNT_W'(PITCH_W);
            state   <= WS_PITCH;
          end
          WS_PITCH: begin
            if (rep_reg) begin
              frame_valid  <= 1'b1;
              frame_kind   <= FK_REPEAT;
              frame_energy <= e_reg;
              frame_pitch  <= fld;
              cnt          <= CNT_W'(ENERGY_W);
              state        <= WS_ENERGY;
            end else begin
              p_reg    <= fld;
              kind_reg <= kind_of_pitch(fld);
              cnt      <= skip_len(fld);
              state    <= WS_SKIP;
            end
          end
          WS_SKIP: begin
            frame_valid  <= 1'b1;
            frame_kind   <= kind_reg;
            frame_energy <= e_reg;
            frame_pitch  <= p_reg;
            cnt          <= CNT_W'(ENERGY_W);
            state        <= WS_ENERGY;
          end
          default: state <= WS_IDLE;
        endcase
      end
    end
  end

  // R8: strobe lasts a single cycle
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    frame_valid |=> !frame_valid);
  // R3: silence reports zero energy and pitch
  p_silence_fields_r3: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && frame_kind == FK_SILENCE) |-> (frame_energy == '0 && frame_pitch == '0));
  // R4: stop frame comes with done
  p_stop_done_r4: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && frame_kind == FK_STOP) |-> (done && frame_energy == '1));
  // R4: no strobe while done holds
  p_quiet_after_stop_r4: assert property (@(posedge clk) disable iff (rst)
    (done && $past(done)) |-> !frame_valid);
  // R6: unvoiced frames carry pitch 0
  p_unvoiced_pitch_r6: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && frame_kind == FK_UNVOICED) |-> (frame_pitch == '0));
  // R7: voiced frames carry nonzero pitch
  p_voiced_pitch_r7: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && frame_kind == FK_VOICED) |-> (frame_pitch != '0));
  // R5: repeat/unvoiced/voiced energies lie strictly between the markers
  p_mid_energy_r5: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && frame_kind inside {FK_REPEAT, FK_UNVOICED, FK_VOICED})
      |-> (frame_energy != '0 && frame_energy != '1));
  // R9: a start pulse clears done
  p_restart_clears_r9: assert property (@(posedge clk) disable iff (rst)
    start |=> !done);

endmodule

// File: rtl/speech_frame_parser.sv
module speech_frame_parser
  import sfp_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_bit,
  output logic              mem_rd,
  output logic [ADDR_W-4:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              frame_valid,
  output logic [2:0]        frame_kind,
  output logic [3:0]        frame_energy,
  output logic [5:0]        frame_pitch,
  output logic              done
);
  logic        rd_run, rd_take, rd_bit_ok, rd_bit_val;
  frame_kind_t kind_w;

  sfp_bit_reader #(.ADDR_W(ADDR_W)) u_reader (
    .clk       (clk),
    .rst       (rst),
    .load      (start),
    .load_addr (start_bit),
    .run       (rd_run),
    .take      (rd_take),
    .mem_rd    (mem_rd),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .bit_ok    (rd_bit_ok),
    .bit_val   (rd_bit_val)
  );

  sfp_frame_walker u_walker (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .bit_ok       (rd_bit_ok),
    .bit_val      (rd_bit_val),
    .run          (rd_run),
    .take         (rd_take),
    .frame_valid  (frame_valid),
    .frame_kind   (kind_w),
    .frame_energy (frame_energy),
    .frame_pitch  (frame_pitch),
    .done         (done)
  );

  assign frame_kind = kind_w;

  // R11: nothing is read or reported while reset holds the block
  p_reset_quiet_r11: assert property (@(posedge clk)
    rst |=> (!frame_valid && !done));

endmodule

// File: tb/speech_frame_parser_test.sv
module speech_frame_parser_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 13;
  localparam int MAXF = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] start_bit = '0;
  logic          mem_rd;
  logic [AW-4:0] mem_addr;
  logic [7:0]    mem_rdata;
  logic          frame_valid;
  logic [2:0]    frame_kind;
  logic [3:0]    frame_energy;
  logic [5:0]    frame_pitch;
  logic          done;

  logic [7:0] mem [0:(1<<(AW-3))-1];
  logic [7:0] mem_q = '0;

  int checks = 0;
  int errors = 0;
  int wp = 0;
  int exp_n [2];
  int exp_k [2][MAXF];
  int exp_e [2][MAXF];
  int exp_p [2][MAXF];

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory with one cycle of read latency (R10)
  always @(posedge clk) if (mem_rd) mem_q <= mem[mem_addr];
  assign mem_rdata = mem_q;

  speech_frame_parser #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .start(start), .start_bit(start_bit),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .frame_valid(frame_valid), .frame_kind(frame_kind),
    .frame_energy(frame_energy), .frame_pitch(frame_pitch), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // R1: bit n lives in byte n/8 at position 7-(n%8)
  task automatic put_bit(input bit b);
    mem[wp / 8][7 - (wp % 8)] = b;
    wp++;
  endtask

  // R2: fields written first bit = most significant
  task automatic put_bits(input int v, input int n);
    for (int i = n - 1; i >= 0; i--) put_bit(v[i]);
  endtask

  task automatic add_frame(input int sid, input int k, input int e, input int p);
    int n;
    n = exp_n[sid];
    case (k)
      0: begin put_bits(0, 4); e = 0; p = 0; end
      4: begin put_bits(15, 4); e = 15; p = 0; end
      1: begin put_bits(e, 4); put_bit(1'b1); put_bits(p, 6); end
      2: begin p = 0; put_bits(e, 4); put_bit(1'b0); put_bits(0, 6); put_bits($urandom, 18); end
      default: begin put_bits(e, 4); put_bit(1'b0); put_bits(p, 6);
                     put_bits($urandom, 32); put_bits($urandom, 5); end
    endcase
    exp_k[sid][n] = k; exp_e[sid][n] = e; exp_p[sid][n] = p;
    exp_n[sid] = n + 1;
  endtask

  function automatic string kind_tag(input int k);
    case (k)
      0: return "R3 silence frame";
      1: return "R5 repeat frame";
      2: return "R6 unvoiced frame";
      3: return "R7 voiced frame";
      default: return "R4 stop frame";
    endcase
  endfunction

  task automatic check_frame(input int sid, input int idx);
    int act, expv;
    act  = (int'(frame_kind) << 16) | (int'(frame_energy) << 8) | int'(frame_pitch);
    expv = (exp_k[sid][idx] << 16) | (exp_e[sid][idx] << 8) | exp_p[sid][idx];
    // fields depend on R1 bit order, R2 field order and R10 byte fetches
    chk(act == expv, kind_tag(exp_k[sid][idx]), act, expv);
  endtask

  task automatic run_stream(input int sid, input int baddr, input bit restart,
                            input int sid2, input int baddr2);
    int cur, idx, wd, extra;
    bit fin;
    cur = sid; idx = 0; wd = 0; fin = 0; extra = 0;
    @(negedge clk); start_bit = AW'(baddr); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(done == 1'b0, "R9 done cleared by start", int'(done), 0);
    while (!fin) begin
      if (frame_valid) begin
        if (idx >= exp_n[cur]) chk(1'b0, "R8 extra frame strobe", idx, exp_n[cur]);
        else check_frame(cur, idx);
        idx++;
        if (restart && cur == sid) begin
          cur = sid2; idx = 0;
          start_bit = AW'(baddr2); start = 1'b1;
          @(negedge clk); start = 1'b0;
          chk(done == 1'b0 && frame_valid == 1'b0, "R9 restart mid-stream", int'(done), 0);
        end
      end
      if (done) begin
        fin = 1;
        chk(idx == exp_n[cur], "R4 frame count at done", idx, exp_n[cur]);
      end
      wd++;
      if (wd > 20000) begin
        fin = 1;
        chk(1'b0, "R4 watchdog expired before done", wd, 20000);
      end
      if (!fin) @(negedge clk);
    end
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (frame_valid) extra++;
    end
    chk(extra == 0 && done == 1'b1, "R4 quiet after stop", extra, 0);
  endtask

  initial begin
    int base;
    void'($urandom(32'd20240611));
    for (int i = 0; i < (1 << (AW - 3)); i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(frame_valid == 1'b0 && done == 1'b0 && mem_rd == 1'b0, "R11 reset state",
        int'(frame_valid) + int'(done) + int'(mem_rd), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(mem_rd == 1'b0 && frame_valid == 1'b0, "R11 idle without start",
        int'(mem_rd), 0);

    // directed, aligned: all kinds, repeat with pitch 0, pitch extremes
    exp_n[0] = 0; wp = 0;
    add_frame(0, 0, 0, 0);  add_frame(0, 1, 5, 33); add_frame(0, 2, 9, 0);
    add_frame(0, 3, 14, 63); add_frame(0, 3, 1, 1); add_frame(0, 0, 0, 0);
    add_frame(0, 1, 14, 0); add_frame(0, 4, 0, 0);
    run_stream(0, 0, 1'b0, 0, 0);

    // directed, unaligned start (R9, R10 straddling fields)
    exp_n[0] = 0; wp = 5;
    add_frame(0, 1, 2, 62); add_frame(0, 3, 13, 32); add_frame(0, 2, 7, 0);
    add_frame(0, 0, 0, 0);  add_frame(0, 1, 1, 1);   add_frame(0, 4, 0, 0);
    run_stream(0, 5, 1'b0, 0, 0);

    // stop frame alone, straddling a byte (R4, R10)
    exp_n[0] = 0; wp = 7;
    add_frame(0, 4, 0, 0);
    run_stream(0, 7, 1'b0, 0, 0);

    // restart during a stream (R9)
    exp_n[0] = 0; wp = 3;
    add_frame(0, 3, 7, 20); add_frame(0, 3, 8, 21); add_frame(0, 4, 0, 0);
    exp_n[1] = 0; wp = 4101;
    add_frame(1, 1, 3, 2); add_frame(1, 0, 0, 0); add_frame(1, 2, 11, 0);
    add_frame(1, 4, 0, 0);
    run_stream(0, 3, 1'b1, 1, 4101);

    // random streams at random offsets
    for (int r = 0; r < 6; r++) begin
      base = $urandom_range(0, 15);
      exp_n[0] = 0; wp = base;
      for (int f = 0; f < 10; f++) begin
        int k, e, p;
        k = $urandom_range(0, 3);
        e = $urandom_range(1, 14);
        p = (k == 3) ? $urandom_range(1, 63) : $urandom_range(0, 63);
        add_frame(0, k, e, p);
      end
      add_frame(0, 4, 0, 0);
      run_stream(0, base, 1'b0, 0, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule